// File: doc/BRIEF.md
# Ethernet Pause Frame Generator

This block builds flow-control pause frames on the transmit side of an Ethernet MAC. A request can come from any of three places. One software strobe asks for a frame carrying the programmed quantum. A second software strobe asks for a frame carrying a quantum of zero. A hardware input asks for a frame each time it changes level. The hardware request is ignored when its priority-flow-control select is high. When it is accepted, a zero-select qualifier picks between the programmed quantum and zero. A request is accepted only while full-duplex operation is selected and the transmitter is enabled.

An accepted request is held as pending, together with the station address and the chosen quantum, until the normal frame stream is idle. The block then raises its busy flag and sends a complete minimum-length frame as a byte stream with a valid/ready handshake. The stream is made of the header, the quantum, zero padding and a CRC-32 frame check sequence. Once the last byte is accepted, the block gives a one-cycle interrupt pulse and increments the count of pause frames sent.

Top module: `pause_frame_gen`

## Requirements
- R1: Bytes 0..17 of a frame are 01 80 C2 00 00 01, then the six station-address bytes with bits 47:40 first, then 88 08, then 00 01, then the quantum with the high byte first.
- R2: Bytes 18..59 are 0x00. A frame has exactly 64 bytes, and `tx_last_o` is high only with byte 63.
- R3: Bytes 60..63 carry the CRC-32 of bytes 0..59, least significant byte first. The CRC uses the reflected polynomial 0xEDB88320, starts from all ones and is inverted at the end.
- R4: The programmed quantum is 0xFFFF after reset and takes `quanta_wdata_i` in any cycle with `quanta_wr_i` high.
- R5: `sw_send_i` requests a frame with the programmed quantum, and `sw_send_zero_i` requests a frame with quantum 0. When both are high in the same cycle, the zero request wins.
- R6: A level change on `hw_pause_i` while `hw_pfc_sel_i` is low requests a frame. Its quantum is 0 if `hw_zero_sel_i` is high and the programmed quantum otherwise. Changes on `hw_pause_i` while `hw_pfc_sel_i` is high produce no frame.
- R7: A request arriving while `full_duplex_i` or `tx_enable_i` is low is dropped. It does not produce a frame later, after both inputs go high again.
- R8: A pending frame starts only in a cycle with `mac_busy_i` low. `pause_busy_o` is high from the first byte to the last.
- R9: While `tx_valid_o` is high and `tx_ready_i` is low, `tx_valid_o` and `tx_data_o` hold.
- R10: The quantum and station address are captured when a request is accepted. Changes to `quanta_wdata_i`/`quanta_wr_i` or `station_addr_i` during a frame leave that frame unchanged.
- R11: Requests made while one is already pending merge into a single frame that carries the newest request's quantum.
- R12: One cycle after the last byte is accepted, `pause_irq_o` pulses for one cycle and `pause_tx_count_o` increments by one. Neither changes at any other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_send_i | input | 1 | Software strobe: frame with programmed quantum |
| sw_send_zero_i | input | 1 | Software strobe: frame with zero quantum |
| hw_pause_i | input | 1 | Asynchronous toggle request |
| hw_zero_sel_i | input | 1 | Toggle request uses zero quantum |
| hw_pfc_sel_i | input | 1 | Toggle request belongs to priority flow control (ignored) |
| station_addr_i | input | 48 | Source address placed in frames |
| quanta_wr_i | input | 1 | Write strobe for the programmed quantum |
| quanta_wdata_i | input | 16 | New programmed quantum |
| full_duplex_i | input | 1 | Full duplex selected |
| tx_enable_i | input | 1 | Transmitter enabled |
| mac_busy_i | input | 1 | Normal frame in progress |
| tx_ready_i | input | 1 | Downstream accepts a byte |
| tx_valid_o | output | 1 | Byte valid |
| tx_data_o | output | 8 | Frame byte |
| tx_last_o | output | 1 | Last byte of frame |
| pause_busy_o | output | 1 | Pause frame being sent |
| pause_irq_o | output | 1 | One-cycle frame-sent pulse |
| pause_tx_count_o | output | 16 | Pause frames sent |

## Verification
Every frame is compared byte for byte with a model built from the requirements. The cases differ in quantum source: the reset default, a written value, zero by strobe, and both hardware zero-select settings. Because each case uses a different quantum or address, a wrong field order or a stale value shows up as a byte mismatch. A stalling ready pattern shows whether bytes repeat, skip or change while held. Blocking cases (priority-flow-control select, half duplex, disabled transmitter, busy MAC) show whether a request is dropped, held back or wrongly kept. A merge case and a mid-frame register change show whether a request is latched and merged correctly.

// File: rtl/pause_pkg.sv
package pause_pkg;
  localparam logic [47:0] CTRL_DEST_ADDR = 48'h0180C2000001;
  localparam logic [15:0] CTRL_ETHERTYPE = 16'h8808;
  localparam logic [15:0] PAUSE_OPCODE   = 16'h0001;
  localparam int          HDR_BYTES      = 18;
  localparam int          FCS_BYTES      = 4;

  typedef struct packed {
    logic [15:0] quanta;
    logic [47:0] src_addr;
  } pause_req_t;

  function automatic logic [31:0] crc32_next(input logic [31:0] crc, input logic [7:0] data);
    logic [31:0] c;
    c = crc;
    for (int b = 0; b < 8; b++) begin
      if (c[0] ^ data[b]) c = (c >> 1) ^ 32'hEDB88320;
      else                c = c >> 1;
    end
    return c;
  endfunction
endpackage

// File: rtl/pause_toggle_detect.sv
module pause_toggle_detect #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic toggle_o
);
  logic [SYNC_STAGES-1:0] sync_q, sync_d;
  logic                   prev_q;

  always_comb begin
    sync_d = {sync_q[SYNC_STAGES-2:0], async_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      prev_q <= sync_q[SYNC_STAGES-1];
    end
  end

  assign toggle_o = sync_q[SYNC_STAGES-1] ^ prev_q;
endmodule

// File: rtl/pause_req_ctrl.sv
module pause_req_ctrl
  import pause_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sw_send_i,
  input  logic        sw_send_zero_i,
  input  logic        hw_toggle_i,
  input  logic        hw_zero_sel_i,
  input  logic        hw_pfc_sel_i,
  input  logic        full_duplex_i,
  input  logic        tx_enable_i,
  input  logic [15:0] prog_quanta_i,
  input  logic [47:0] station_addr_i,
  input  logic        start_i,
  output logic        pend_o,
  output pause_req_t  pend_req_o
);
  logic       pend_q, pend_d;
  pause_req_t req_q, req_d;
  logic       allowed, hw_req, any_req, use_zero;

  always_comb begin
    allowed  = full_duplex_i & tx_enable_i;
    hw_req   = hw_toggle_i & ~hw_pfc_sel_i;
    any_req  = allowed & (sw_send_i | sw_send_zero_i | hw_req);
    use_zero = sw_send_zero_i | (~sw_send_i & hw_zero_sel_i);
    pend_d   = pend_q;
    req_d    = req_q;
    if (start_i) pend_d = 1'b0;
    if (any_req) begin
      pend_d         = 1'b1;
      req_d.quanta   = use_zero ? 16'h0000 : prog_quanta_i;
      req_d.src_addr = station_addr_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      req_q  <= '0;
    end else begin
      pend_q <= pend_d;
      req_q  <= req_d;
    end
  end

  assign pend_o     = pend_q;
  assign pend_req_o = req_q;
endmodule

// File: rtl/pause_frame_tx.sv
module pause_frame_tx
  import pause_pkg::*;
#(
  parameter int MIN_LEN = 60
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  pause_req_t req_i,
  input  logic       tx_ready_i,
  output logic       tx_valid_o,
  output logic [7:0] tx_data_o,
  output logic       tx_last_o,
  output logic       busy_o,
  output logic       done_o
);
  localparam int TOTAL = MIN_LEN + FCS_BYTES;
  localparam int IDX_W = $clog2(TOTAL);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(TOTAL - 1);

  logic             active_q, active_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [31:0]      crc_q, crc_d;
  pause_req_t       req_q, req_d;
  logic             done_q, done_d;
  logic [143:0]     hdr;
  logic [31:0]      fcs;
  logic [7:0]       byte_c;
  logic             hs;

  always_comb begin
    hdr = {CTRL_DEST_ADDR, req_q.src_addr, CTRL_ETHERTYPE, PAUSE_OPCODE, req_q.quanta};
    fcs = ~crc_q;
    if (int'(idx_q) < HDR_BYTES)     byte_c = hdr[143 - 8*int'(idx_q) -: 8];
    else if (int'(idx_q) < MIN_LEN)  byte_c = 8'h00;
    else                             byte_c = fcs[8*(int'(idx_q) - MIN_LEN) +: 8];
  end

  always_comb begin
    hs       = active_q & tx_ready_i;
    active_d = active_q;
    idx_d    = idx_q;
    crc_d    = crc_q;
    req_d    = req_q;
    done_d   = 1'b0;
    if (start_i && !active_q) begin
      active_d = 1'b1;
      idx_d    = '0;
      crc_d    = 32'hFFFFFFFF;
      req_d    = req_i;
    end else if (hs) begin
      if (int'(idx_q) < MIN_LEN) crc_d = crc32_next(crc_q, byte_c);
      if (idx_q == IDX_LAST) begin
        active_d = 1'b0;
        done_d   = 1'b1;
      end else begin
        idx_d = idx_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      idx_q    <= '0;
      crc_q    <= '0;
      req_q    <= '0;
      done_q   <= 1'b0;
    end else begin
      active_q <= active_d;
      idx_q    <= idx_d;
      crc_q    <= crc_d;
      req_q    <= req_d;
      done_q   <= done_d;
    end
  end

  assign tx_valid_o = active_q;
  assign tx_data_o  = byte_c;
  assign tx_last_o  = active_q & (idx_q == IDX_LAST);
  assign busy_o     = active_q;
  assign done_o     = done_q;
endmodule

// File: rtl/pause_frame_gen.sv
module pause_frame_gen
  import pause_pkg::*;
#(
  parameter int MIN_LEN     = 60,
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sw_send_i,
  input  logic             sw_send_zero_i,
  input  logic             hw_pause_i,
  input  logic             hw_zero_sel_i,
  input  logic             hw_pfc_sel_i,
  input  logic [47:0]      station_addr_i,
  input  logic             quanta_wr_i,
  input  logic [15:0]      quanta_wdata_i,
  input  logic             full_duplex_i,
  input  logic             tx_enable_i,
  input  logic             mac_busy_i,
  input  logic             tx_ready_i,
  output logic             tx_valid_o,
  output logic [7:0]       tx_data_o,
  output logic             tx_last_o,
  output logic             pause_busy_o,
  output logic             pause_irq_o,
  output logic [CNT_W-1:0] pause_tx_count_o
);
  logic [15:0]      quanta_q, quanta_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             hw_toggle, pend, start, busy, done;
  pause_req_t       pend_req;

  pause_toggle_detect #(.SYNC_STAGES(SYNC_STAGES)) i_toggle (
    .clk(clk), .rst_n(rst_n), .async_i(hw_pause_i), .toggle_o(hw_toggle)
  );

  pause_req_ctrl i_req (
    .clk(clk), .rst_n(rst_n),
    .sw_send_i(sw_send_i), .sw_send_zero_i(sw_send_zero_i),
    .hw_toggle_i(hw_toggle), .hw_zero_sel_i(hw_zero_sel_i), .hw_pfc_sel_i(hw_pfc_sel_i),
    .full_duplex_i(full_duplex_i), .tx_enable_i(tx_enable_i),
    .prog_quanta_i(quanta_q), .station_addr_i(station_addr_i),
    .start_i(start), .pend_o(pend), .pend_req_o(pend_req)
  );

  assign start = pend & ~busy & ~mac_busy_i;

  pause_frame_tx #(.MIN_LEN(MIN_LEN)) i_tx (
    .clk(clk), .rst_n(rst_n), .start_i(start), .req_i(pend_req),
    .tx_ready_i(tx_ready_i), .tx_valid_o(tx_valid_o), .tx_data_o(tx_data_o),
    .tx_last_o(tx_last_o), .busy_o(busy), .done_o(done)
  );

  always_comb begin
    quanta_d = quanta_q;
    cnt_d    = cnt_q;
    if (quanta_wr_i) quanta_d = quanta_wdata_i;
    if (tx_valid_o && tx_ready_i && tx_last_o) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      quanta_q <= 16'hFFFF;
      cnt_q    <= '0;
    end else begin
      quanta_q <= quanta_d;
      cnt_q    <= cnt_d;
    end
  end

  assign pause_busy_o     = busy;
  assign pause_irq_o      = done;
  assign pause_tx_count_o = cnt_q;
endmodule

// File: rtl/pause_frame_gen_chk.sv
module pause_frame_gen_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             mac_busy_i,
  input logic             tx_ready_i,
  input logic             tx_valid_o,
  input logic [7:0]       tx_data_o,
  input logic             tx_last_o,
  input logic             pause_busy_o,
  input logic             pause_irq_o,
  input logic [CNT_W-1:0] pause_tx_count_o
);
  AST_HOLD_WHILE_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid_o && !tx_ready_i) |=> (tx_valid_o && $stable(tx_data_o))); // R9
  AST_START_ONLY_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_valid_o) |-> !$past(mac_busy_i)); // R8
  AST_BUSY_COVERS_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid_o |-> pause_busy_o); // R8
  AST_LAST_IS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    tx_last_o |-> tx_valid_o); // R2
  AST_IRQ_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    pause_irq_o |-> $past(tx_valid_o && tx_ready_i && tx_last_o)); // R12
  AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    pause_irq_o |=> !pause_irq_o); // R12
  AST_COUNT_WITH_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (pause_tx_count_o != $past(pause_tx_count_o)) |-> pause_irq_o); // R12
endmodule

bind pause_frame_gen pause_frame_gen_chk #(.CNT_W(CNT_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .mac_busy_i(mac_busy_i), .tx_ready_i(tx_ready_i),
  .tx_valid_o(tx_valid_o), .tx_data_o(tx_data_o), .tx_last_o(tx_last_o),
  .pause_busy_o(pause_busy_o), .pause_irq_o(pause_irq_o),
  .pause_tx_count_o(pause_tx_count_o)
);

// File: tb/test_pause_frame_gen.sv
module test_pause_frame_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sw_send_i = 0, sw_send_zero_i = 0, hw_pause_i = 0;
  logic        hw_zero_sel_i = 0, hw_pfc_sel_i = 0;
  logic [47:0] station_addr_i = 48'h02AABBCCDDEE;
  logic        quanta_wr_i = 0;
  logic [15:0] quanta_wdata_i = 0;
  logic        full_duplex_i = 1, tx_enable_i = 1, mac_busy_i = 0, tx_ready_i = 1;
  logic        tx_valid_o, tx_last_o, pause_busy_o, pause_irq_o;
  logic [7:0]  tx_data_o;
  logic [15:0] pause_tx_count_o;

  int checks = 0, errors = 0, cycles = 0, irq_seen = 0, exp_cnt = 0;
  logic [7:0] exp_frame [64];

  always #4 clk = ~clk;

  pause_frame_gen i_pause_frame_gen (.*);

  always @(negedge clk) begin
    cycles++;
    if (pause_irq_o) irq_seen++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected < 100000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic build(input logic [15:0] q, input logic [47:0] sa);
    logic [31:0] c;
    logic [7:0] d;
    for (int i = 0; i < 64; i++) exp_frame[i] = 8'h00;
    exp_frame[0] = 8'h01; exp_frame[1] = 8'h80; exp_frame[2] = 8'hC2;
    exp_frame[3] = 8'h00; exp_frame[4] = 8'h00; exp_frame[5] = 8'h01;
    for (int i = 0; i < 6; i++) exp_frame[6+i] = sa[8*(5-i) +: 8];
    exp_frame[12] = 8'h88; exp_frame[13] = 8'h08;
    exp_frame[14] = 8'h00; exp_frame[15] = 8'h01;
    exp_frame[16] = q[15:8]; exp_frame[17] = q[7:0];
    c = 32'hFFFFFFFF;
    for (int i = 0; i < 60; i++) begin
      d = exp_frame[i];
      for (int b = 0; b < 8; b++) begin
        c = {1'b0, c[31:1]} ^ (((c[0] ^ d[b]) == 1'b1) ? 32'hEDB88320 : 32'h0);
      end
    end
    c = ~c;
    for (int k = 0; k < 4; k++) exp_frame[60+k] = c[8*k +: 8];
  endtask

  task automatic pulse_send(input bit zero);
    @(negedge clk);
    if (zero) sw_send_zero_i = 1; else sw_send_i = 1;
    @(negedge clk);
    sw_send_i = 0; sw_send_zero_i = 0;
  endtask

  // mode 0: ready always high, 1: stalls, 2: stalls and register changes mid-frame
  task automatic recv(input logic [15:0] q, input logic [47:0] sa, input int mode, input string req);
    int n = 0, wait_c = 0, bad = 0, first_bad = -1, stall_bad = 0, last_bad = 0, irq0;
    logic [7:0] held;
    bit holding = 0;
    logic [7:0] act_bad = 0;
    build(q, sa);
    irq0 = irq_seen;
    while (n < 64 && wait_c < 2000) begin
      @(negedge clk);
      wait_c++;
      if (mode == 2 && n == 8) begin
        quanta_wr_i = 1; quanta_wdata_i = 16'hBEEF; station_addr_i = 48'h111111111111;
      end else begin
        quanta_wr_i = 0;
      end
      if (holding && (!tx_valid_o || tx_data_o != held)) stall_bad++;
      tx_ready_i = (mode == 0) ? 1'b1 : ((wait_c % 3) != 0);
      holding = 0;
      if (tx_valid_o && tx_ready_i) begin
        if (tx_data_o != exp_frame[n]) begin
          bad++;
          if (first_bad < 0) begin first_bad = n; act_bad = tx_data_o; end
        end
        if (tx_last_o != (n == 63)) last_bad++;
        n++;
      end else if (tx_valid_o) begin
        holding = 1; held = tx_data_o;
      end
    end
    @(negedge clk);
    tx_ready_i = 1; quanta_wr_i = 0;
    check(n == 64, "R2", "byte count", n, 64);
    check(bad == 0, req, $sformatf("frame byte %0d", first_bad), act_bad,
          first_bad < 0 ? 0 : exp_frame[first_bad]);
    check(last_bad == 0, "R2", "tx_last position errors", last_bad, 0);
    if (mode != 0) check(stall_bad == 0, "R9", "hold while stalled", stall_bad, 0);
    @(negedge clk);
    exp_cnt++;
    check(pause_tx_count_o == 16'(exp_cnt), "R12", "counter", pause_tx_count_o, exp_cnt);
    check(irq_seen == irq0 + 1, "R12", "irq pulses", irq_seen - irq0, 1);
  endtask

  task automatic expect_quiet(input int n, input string req);
    int seen = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (tx_valid_o || pause_busy_o) seen++;
    end
    check(seen == 0, req, "no frame", seen, 0);
    check(pause_tx_count_o == 16'(exp_cnt), req, "counter unchanged", pause_tx_count_o, exp_cnt);
  endtask

  task automatic t_reset;
    check(!tx_valid_o && !pause_busy_o && !pause_irq_o, "R8", "idle after reset", tx_valid_o, 0);
    check(pause_tx_count_o == 0, "R12", "count after reset", pause_tx_count_o, 0);
  endtask

  task automatic t_default_quanta;  // R4 R1 R3
    pulse_send(0);
    recv(16'hFFFF, 48'h02AABBCCDDEE, 0, "R4");
  endtask

  task automatic t_written_and_zero;  // R5
    @(negedge clk); quanta_wr_i = 1; quanta_wdata_i = 16'h1234;
    @(negedge clk); quanta_wr_i = 0;
    pulse_send(0);
    recv(16'h1234, 48'h02AABBCCDDEE, 1, "R5");
    pulse_send(1);
    recv(16'h0000, 48'h02AABBCCDDEE, 0, "R5");
    @(negedge clk); sw_send_i = 1; sw_send_zero_i = 1;
    @(negedge clk); sw_send_i = 0; sw_send_zero_i = 0;
    recv(16'h0000, 48'h02AABBCCDDEE, 0, "R5");
  endtask

  task automatic t_hw_toggle;  // R6
    station_addr_i = 48'h3C4D5E6F7081;
    @(negedge clk); hw_zero_sel_i = 0; hw_pause_i = ~hw_pause_i;
    recv(16'h1234, 48'h3C4D5E6F7081, 0, "R6");
    @(negedge clk); hw_zero_sel_i = 1; hw_pause_i = ~hw_pause_i;
    recv(16'h0000, 48'h3C4D5E6F7081, 0, "R6");
    hw_zero_sel_i = 0;
    @(negedge clk); hw_pfc_sel_i = 1; hw_pause_i = ~hw_pause_i;
    expect_quiet(20, "R6");
    hw_pfc_sel_i = 0;
    expect_quiet(10, "R6");
  endtask

  task automatic t_qualifiers;  // R7
    full_duplex_i = 0;
    pulse_send(0);
    expect_quiet(10, "R7");
    full_duplex_i = 1;
    expect_quiet(10, "R7");
    tx_enable_i = 0;
    @(negedge clk); hw_pause_i = ~hw_pause_i;
    expect_quiet(10, "R7");
    tx_enable_i = 1;
    expect_quiet(10, "R7");
  endtask

  task automatic t_mac_busy_and_merge;  // R8 R11
    mac_busy_i = 1;
    pulse_send(0);
    expect_quiet(15, "R8");
    mac_busy_i = 0;
    recv(16'h1234, 48'h3C4D5E6F7081, 0, "R8");
    mac_busy_i = 1;
    pulse_send(0);
    pulse_send(1);
    expect_quiet(5, "R11");
    mac_busy_i = 0;
    recv(16'h0000, 48'h3C4D5E6F7081, 0, "R11");
    expect_quiet(20, "R11");
  endtask

  task automatic t_latch;  // R10
    pulse_send(0);
    recv(16'h1234, 48'h3C4D5E6F7081, 2, "R10");
    pulse_send(0);
    recv(16'hBEEF, 48'h111111111111, 0, "R4");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_default_quanta();
    t_written_and_zero();
    t_hw_toggle();
    t_qualifiers();
    t_mac_busy_and_merge();
    t_latch();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule